// File: doc/BRIEF.md
# Associative Tag Directory with Recency Victim Selection

This block is a sixteen-slot associative directory. Each slot holds a 32-bit tag, a 4-bit state value and a valid bit. A lookup compares its key against every valid slot in the same cycle. On a hit it reports the slot number and that slot's state. On a miss it reports the slot that has gone unused the longest, so the caller can overwrite that slot straight away without a second search.

A separate write command puts a tag and a state into a chosen slot and marks it valid. A clear command invalidates every slot. Recency is kept as a rank per slot. Hits and writes move a slot to the most-recent position. Misses leave the order unchanged. The block suits small cache directories and the index of an array of queues.

All results are registered, with one cycle of latency. Reset is synchronous and active high, and it has the same effect as a clear.

Top module: `cam_lru_dir`

## Requirements
- R1: After reset or a clear, every slot is invalid and the recency order runs from slot 0 (least recent) up to slot 15 (most recent). A lookup that misses right afterwards reports slot 0.
- R2: A lookup accepted in cycle t raises `res_valid` in cycle t+1 only. If no lookup was accepted in cycle t, `res_valid` is low in cycle t+1.
- R3: On a hit, `res_hit` is 1, `res_idx` is the matching slot, and `res_state` is the 4-bit state stored in that slot.
- R4: A slot that is invalid never matches, even when its old tag equals the key.
- R5: When several valid slots match the key, the lowest-numbered slot is reported.
- R6: On a miss, `res_hit` is 0 and `res_idx` is the least-recently-used slot. A miss does not change the recency order.
- R7: A hit makes the matching slot the most recently used.
- R8: A write stores its tag and state, marks the slot valid and makes it the most recently used. A lookup in the same cycle sees the contents from before the write. When a hit and a write land in the same cycle, the written slot ends up most recent.
- R9: A clear takes priority over everything else. A lookup in the same cycle produces no result, and a write in the same cycle is discarded.
- R10: While `res_valid` is low, `res_hit`, `res_idx` and `res_state` are all 0. On a miss, `res_state` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_req | input | 1 | Invalidate all slots and restore the default recency order |
| lk_valid | input | 1 | Lookup request |
| lk_key | input | 32 | Lookup key |
| wr_valid | input | 1 | Write request |
| wr_idx | input | 4 | Slot to write |
| wr_tag | input | 32 | Tag to store |
| wr_state | input | 4 | State to store |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Key was found |
| res_idx | output | 4 | Matching slot on a hit, victim slot on a miss |
| res_state | output | 4 | State of the matching slot on a hit, 0 otherwise |

## Verification
The assertions assume that `clr_req` is held low while reset is asserted. They also assume that every input is at a known 0 or 1 on each clock edge. This matters because the check that restores the order after a clear looks back one cycle at `clr_req`. The bench drives every input to a known value from time zero and keeps `clr_req` low during reset. Its random phase draws keys from a set of six tags, which produces frequent duplicate slots, lookups and writes in the same cycle, and occasional clears, without ever leaving the assumed input space.

// File: rtl/cam_lru_pkg.sv
package cam_lru_pkg;

    localparam int CAM_ENTRIES = 16;
    localparam int CAM_TAG_W   = 32;
    localparam int CAM_STATE_W = 4;

    // Action taken by the directory in a given cycle.
    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_CLEAR  = 2'd1,
        ACT_SEARCH = 2'd2
    } cam_act_e;

    // Decide the cycle's action. A clear overrides any lookup.
    function automatic cam_act_e decode_act(input logic clr, input logic lk);
        if (clr)     return ACT_CLEAR;
        else if (lk) return ACT_SEARCH;
        else         return ACT_IDLE;
    endfunction

endpackage

// File: rtl/cam_first_match.sv
// Lowest-index priority encoder over a request vector.
module cam_first_match #(
    parameter int N = cam_lru_pkg::CAM_ENTRIES,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/cam_entry_store.sv
// Slot storage with a parallel comparator for each slot.
module cam_entry_store #(
    parameter int N  = cam_lru_pkg::CAM_ENTRIES,
    parameter int TW = cam_lru_pkg::CAM_TAG_W,
    parameter int SW = cam_lru_pkg::CAM_STATE_W,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TW-1:0]    wr_tag,
    input  logic [SW-1:0]    wr_state,
    input  logic [TW-1:0]    key,
    output logic [N-1:0]     match_vec,
    output logic [N*SW-1:0]  state_flat
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        logic          vld_q;
        logic [TW-1:0] tag_q;
        logic [SW-1:0] st_q;
        logic          sel;

        assign sel = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                vld_q <= 1'b0;
            end else if (sel) begin
                vld_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q <= '0;
                st_q  <= '0;
            end else if (sel && !clr) begin
                tag_q <= wr_tag;
                st_q  <= wr_state;
            end
        end

        assign match_vec[g]            = vld_q && (tag_q == key);
        assign state_flat[g*SW +: SW]  = st_q;
    end
endmodule

// File: rtl/cam_recency.sv
// Recency ranks per slot: 0 is least recent and N-1 is most recent.
module cam_recency #(
    parameter int N = cam_lru_pkg::CAM_ENTRIES,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             touch_a_en,
    input  logic [IDX_W-1:0] touch_a_idx,
    input  logic             touch_b_en,
    input  logic [IDX_W-1:0] touch_b_idx,
    output logic [N-1:0]     lru_onehot,
    output logic             lru_found,
    output logic [IDX_W-1:0] victim_idx
);
    typedef logic [N-1:0][IDX_W-1:0] rank_t;

    rank_t rank_q;
    rank_t rank_a;
    rank_t rank_d;

    // Move slot k to the most-recent position. Slots that ranked above it drop by one.
    function automatic rank_t promote(input rank_t r, input logic [IDX_W-1:0] k);
        rank_t o;
        o = r;
        for (int i = 0; i < N; i++) begin
            if (r[i] > r[k]) o[i] = r[i] - IDX_W'(1);
        end
        o[k] = IDX_W'(N - 1);
        return o;
    endfunction

    // The hit is applied first and the write second, so the written slot ends up most recent.
    always_comb begin
        rank_a = touch_a_en ? promote(rank_q, touch_a_idx) : rank_q;
        rank_d = touch_b_en ? promote(rank_a, touch_b_idx) : rank_a;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < N; i++) rank_q[i] <= IDX_W'(i);
        end else begin
            rank_q <= rank_d;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_zero
        assign lru_onehot[g] = (rank_q[g] == '0);
    end

    cam_first_match #(.N(N)) u_victim_pick (
        .req   (lru_onehot),
        .found (lru_found),
        .idx   (victim_idx)
    );
endmodule

// File: rtl/cam_lru_dir.sv
module cam_lru_dir
    import cam_lru_pkg::*;
#(
    parameter int N  = CAM_ENTRIES,
    parameter int TW = CAM_TAG_W,
    parameter int SW = CAM_STATE_W,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_req,
    input  logic             lk_valid,
    input  logic [TW-1:0]    lk_key,
    input  logic             wr_valid,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TW-1:0]    wr_tag,
    input  logic [SW-1:0]    wr_state,
    output logic             res_valid,
    output logic             res_hit,
    output logic [IDX_W-1:0] res_idx,
    output logic [SW-1:0]    res_state
);
    typedef struct packed {
        logic             valid;
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic [SW-1:0]    state;
    } result_t;

    cam_act_e         act;
    logic             wr_go;
    logic [N-1:0]     match_vec;
    logic [N*SW-1:0]  state_flat;
    logic             hit_found;
    logic [IDX_W-1:0] hit_idx;
    logic [SW-1:0]    hit_state;
    logic [N-1:0]     lru_onehot;
    logic             lru_found;
    logic [IDX_W-1:0] victim_idx;
    result_t          res_d;
    result_t          res_q;

    assign act   = decode_act(clr_req, lk_valid);
    assign wr_go = wr_valid && !clr_req;

    cam_entry_store #(.N(N), .TW(TW), .SW(SW)) u_store (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr_req),
        .wr_en      (wr_go),
        .wr_idx     (wr_idx),
        .wr_tag     (wr_tag),
        .wr_state   (wr_state),
        .key        (lk_key),
        .match_vec  (match_vec),
        .state_flat (state_flat)
    );

    cam_first_match #(.N(N)) u_hit_pick (
        .req   (match_vec),
        .found (hit_found),
        .idx   (hit_idx)
    );

    assign hit_state = state_flat[hit_idx*SW +: SW];

    cam_recency #(.N(N)) u_recency (
        .clk         (clk),
        .rst         (rst),
        .clr         (clr_req),
        .touch_a_en  ((act == ACT_SEARCH) && hit_found),
        .touch_a_idx (hit_idx),
        .touch_b_en  (wr_go),
        .touch_b_idx (wr_idx),
        .lru_onehot  (lru_onehot),
        .lru_found   (lru_found),
        .victim_idx  (victim_idx)
    );

    always_comb begin
        res_d = '0;
        if (act == ACT_SEARCH) begin
            res_d.valid = 1'b1;
            res_d.hit   = hit_found;
            res_d.idx   = hit_found ? hit_idx : victim_idx;
            res_d.state = hit_found ? hit_state : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign res_valid = res_q.valid;
    assign res_hit   = res_q.hit;
    assign res_idx   = res_q.idx;
    assign res_state = res_q.state;
endmodule

// File: rtl/cam_lru_dir_chk.sv
module cam_lru_dir_chk #(
    parameter int N  = 16,
    parameter int SW = 4,
    localparam int IDX_W = $clog2(N)
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_req,
    input logic             lk_valid,
    input logic             res_valid,
    input logic             res_hit,
    input logic [IDX_W-1:0] res_idx,
    input logic [SW-1:0]    res_state,
    input logic [N-1:0]     lru_onehot,
    input logic             lru_found,
    input logic [IDX_W-1:0] victim_idx
);
    assert_result_after_lookup_R2: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !clr_req) |=> res_valid);

    assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid);

    assert_clear_drops_lookup_R9: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> !res_valid);

    assert_idle_outputs_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_hit && res_idx == '0 && res_state == '0));

    assert_miss_state_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_state == '0));

    assert_single_oldest_R6: assert property (@(posedge clk) disable iff (rst)
        ($countones(lru_onehot) == 1) && lru_found);

    assert_clear_order_restored_R1: assert property (@(posedge clk) disable iff (rst)
        $past(clr_req) |-> (victim_idx == '0));
endmodule

bind cam_lru_dir cam_lru_dir_chk #(.N(N), .SW(SW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_req    (clr_req),
    .lk_valid   (lk_valid),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_idx    (res_idx),
    .res_state  (res_state),
    .lru_onehot (lru_onehot),
    .lru_found  (lru_found),
    .victim_idx (victim_idx)
);

// File: tb/cam_lru_dir_test.sv
`timescale 1ns/1ps
module cam_lru_dir_test;
    localparam int N  = 16;
    localparam int TW = 32;
    localparam int SW = 4;
    localparam int IW = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst = 1'b1;
    logic          clr_req = 1'b0;
    logic          lk_valid = 1'b0;
    logic [TW-1:0] lk_key = '0;
    logic          wr_valid = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [TW-1:0] wr_tag = '0;
    logic [SW-1:0] wr_state = '0;
    logic          res_valid, res_hit;
    logic [IW-1:0] res_idx;
    logic [SW-1:0] res_state;

    cam_lru_dir uut (
        .clk(clk), .rst(rst), .clr_req(clr_req), .lk_valid(lk_valid), .lk_key(lk_key),
        .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_state(wr_state),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx), .res_state(res_state)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_req = "R10";

    // Reference model: valid bits, tags, states and a recency queue with the least recent slot at the front.
    bit            mv [N];
    logic [TW-1:0] mt [N];
    logic [SW-1:0] ms [N];
    int            order [$];
    logic          e_valid, e_hit;
    logic [IW-1:0] e_idx;
    logic [SW-1:0] e_state;

    function automatic logic [TW-1:0] tg(int i);
        return 32'hA500_0000 + TW'(i);
    endfunction

    task automatic model_clear();
        order.delete();
        for (int i = 0; i < N; i++) begin
            mv[i] = 0;
            order.push_back(i);
        end
    endtask

    task automatic touch(int k);
        for (int j = 0; j < order.size(); j++) begin
            if (order[j] == k) begin
                order.delete(j);
                break;
            end
        end
        order.push_back(k);
    endtask

    task automatic check(string req);
        checks++;
        if (res_valid !== e_valid || res_hit !== e_hit || res_idx !== e_idx || res_state !== e_state) begin
            fails++;
            $display("FAIL %s: got v=%0b hit=%0b idx=%0d st=%0d, expected v=%0b hit=%0b idx=%0d st=%0d",
                     req, res_valid, res_hit, res_idx, res_state, e_valid, e_hit, e_idx, e_state);
        end
    endtask

    task automatic step(bit c, bit l, logic [TW-1:0] k, bit w, int wi, logic [TW-1:0] wt, int wsv);
        int hit_at;
        @(negedge clk);
        clr_req = c; lk_valid = l; lk_key = k;
        wr_valid = w; wr_idx = IW'(wi); wr_tag = wt; wr_state = SW'(wsv);
        @(posedge clk);
        e_valid = 0; e_hit = 0; e_idx = '0; e_state = '0;
        if (c) begin
            model_clear();
        end else begin
            hit_at = -1;
            if (l) begin
                for (int i = N - 1; i >= 0; i--) if (mv[i] && mt[i] == k) hit_at = i;
                e_valid = 1;
                if (hit_at >= 0) begin
                    e_hit = 1; e_idx = IW'(hit_at); e_state = ms[hit_at];
                end else begin
                    e_idx = IW'(order[0]);
                end
            end
            if (hit_at >= 0) touch(hit_at);
            if (w) begin
                mv[wi] = 1; mt[wi] = wt; ms[wi] = SW'(wsv);
                touch(wi);
            end
        end
        #1;
        check(cur_req);
    endtask

    task automatic lookup(logic [TW-1:0] k);
        step(0, 1, k, 0, 0, '0, 0);
    endtask

    task automatic write(int wi, logic [TW-1:0] wt, int wsv);
        step(0, 0, '0, 1, wi, wt, wsv);
    endtask

    initial begin
        model_clear();
        e_valid = 0; e_hit = 0; e_idx = '0; e_state = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        cur_req = "R10";
        check(cur_req);

        // R1: the first miss after reset reports slot 0
        cur_req = "R1";
        lookup(32'hDEAD_0000);
        lookup(32'hDEAD_0001);

        // R8 and R6: fill the slots in order; each miss reports the next unwritten slot
        for (int i = 0; i < N; i++) begin
            cur_req = "R8";
            write(i, tg(i), (i * 3) % 16);
            cur_req = "R6";
            lookup(32'hDEAD_0002);
        end

        // R3: every stored tag hits with its own slot and state
        cur_req = "R3";
        for (int i = 0; i < N; i++) lookup(tg(i));

        // R7: hits change which slot is oldest
        cur_req = "R7";
        lookup(32'hDEAD_0003);
        lookup(tg(0));
        lookup(32'hDEAD_0004);
        lookup(tg(1));
        lookup(32'hDEAD_0005);

        // R2: idle cycles give no result
        cur_req = "R2";
        repeat (3) step(0, 0, '0, 0, 0, '0, 0);

        // R5: duplicated tags report the lowest slot
        cur_req = "R5";
        write(9, tg(4), 7);
        lookup(tg(4));
        write(2, tg(4), 11);
        lookup(tg(4));

        // R8: a lookup in the same cycle as a write sees the old contents; hit plus write leaves the written slot newest
        cur_req = "R8";
        step(0, 1, 32'hBEEF_0007, 1, 7, 32'hBEEF_0007, 5);
        lookup(32'hBEEF_0007);
        step(0, 1, tg(5), 1, 6, 32'hBEEF_0006, 9);
        lookup(32'hDEAD_0006);
        lookup(tg(6));

        // R9: clear beats a lookup and a write in the same cycle
        cur_req = "R9";
        step(1, 1, tg(5), 1, 1, 32'hBEEF_0001, 3);
        lookup(32'hBEEF_0001);

        // R4: tags that are still stored but no longer valid do not match
        cur_req = "R4";
        lookup(tg(5));
        lookup(32'hBEEF_0007);

        // R1: the order after a clear is 0 to 15
        cur_req = "R1";
        write(0, tg(0), 1);
        lookup(32'hDEAD_0008);

        // R6: random mix with a small tag space
        cur_req = "R6";
        for (int n = 0; n < 800; n++) begin
            step(($urandom % 60) == 0, $urandom % 2, tg($urandom % 6),
                 $urandom % 2, $urandom % N, tg($urandom % 6), $urandom % 16);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule